// File: doc/BRIEF.md
# SHA-512 Message Schedule Update Unit

This block is a pipelined vector execution unit for the message-expansion part of SHA-512. It takes a 32-bit instruction word together with three 128-bit operands: the old contents of the destination register, a first source and a second source. It returns a 128-bit result for the destination. Every register holds two 64-bit words side by side. Two schedule-update operations are decoded. The first-stage update mixes the two old destination words with the low word of the first source through the small sigma-0 function. The second-stage update adds, word by word, the old destination, the second source and sigma-1 of the first source.

The register file sits outside the block. The unit exposes the two source indices straight from the instruction word, so the surrounding logic can fetch operands in the same cycle that it offers the instruction. Any word that decodes to neither operation still travels through the pipeline. It comes out flagged as illegal, with no write enable, so the issue logic can raise an exception in program order. Input and output each use a valid/ready handshake. The unit accepts one instruction per cycle while the output is drained.

Top module: `sha_sched_unit`

## Requirements
- R1: The instruction word is split as follows. Bits [31:21] must equal 11001110011. Bits [20:16] are the second-source index m, bits [15:10] are the opcode, bits [9:5] are the first-source index n, and bits [4:0] are the destination index d. `src_n_idx` and `src_m_idx` show bits [9:5] and [20:16] of `in_insn` combinationally.
- R2: The second-stage update uses opcode 100010, and the first-stage update uses opcode 100100 (parameter `UPD0_OPC`). Any other word is illegal: this includes opcodes 100000, 100001 and 100011, and any other value of bits [31:21]. An illegal word leaves the unit with `out_illegal`=1, `out_wr_en`=0 and a zero result. A valid output carries exactly one of `out_wr_en` and `out_illegal`.
- R3: sigma0(v) = rotr(v,1) ^ rotr(v,8) ^ (v >> 7) on 64 bits.
- R4: sigma1(v) = rotr(v,19) ^ rotr(v,61) ^ (v >> 6) on 64 bits.
- R5: In the first-stage update, result[63:0] = d[63:0] + sigma0(d[127:64]) and result[127:64] = d[127:64] + sigma0(n[63:0]). The m operand has no effect.
- R6: In the second-stage update, for each word i (word 0 = bits [63:0], word 1 = bits [127:64]), result_i = d_i + m_i + sigma1(n_i). No carry passes between the words.
- R7: Every addition wraps modulo 2^64.
- R8: `out_dst_idx` equals the d field of the instruction that produced the result.
- R9: An instruction accepted at a clock edge appears at the output after the next edge, provided that the output stage is free. Results leave in the order they were accepted, and one instruction per cycle is sustained while `out_ready` stays high.
- R10: While `out_valid`=1 and `out_ready`=0, every output stays unchanged.
- R11: `in_ready` is low only when both pipeline stages hold an instruction and `out_ready` is low.
- R12: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1, and the unit comes out of reset empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands offered |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| in_insn | input | 32 | Instruction word |
| in_opd | input | 128 | Old destination register contents |
| in_opn | input | 128 | First source register contents |
| in_opm | input | 128 | Second source register contents |
| src_n_idx | output | 5 | First-source index decoded from `in_insn` |
| src_m_idx | output | 5 | Second-source index decoded from `in_insn` |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 128 | Value to write to the destination |
| out_dst_idx | output | 5 | Destination register index |
| out_wr_en | output | 1 | Result is to be written |
| out_illegal | output | 1 | Instruction word was not recognised |

## Verification
Single-bit and top-bit source words isolate each rotate and shift of the two sigma functions, with the adders neutralised by zero addends. All-ones words in the low half show the wrap and prove that no carry reaches the high word. A pair of first-stage updates that differ only in the m operand must give identical results. The four neighbouring opcodes and a corrupted prefix separate legal from illegal decode. A long stretch of mixed operations under random input gaps and output stalls then compares latency, ordering, held outputs and ready against a queue model on every cycle.

// File: rtl/sha_sched_pkg.sv
package sha_sched_pkg;

  typedef enum logic [1:0] {
    SCHED_ILLEGAL = 2'd0,
    SCHED_UPD0    = 2'd1,
    SCHED_UPD1    = 2'd2
  } sched_op_e;

  localparam int unsigned INSN_W   = 32;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned OPC_W    = 6;
  localparam int unsigned PREFIX_W = 11;

endpackage

// File: rtl/sha_sched_decode.sv
module sha_sched_decode
  import sha_sched_pkg::*;
#(
  parameter logic [PREFIX_W-1:0] PREFIX   = 11'b11001110011,
  parameter logic [OPC_W-1:0]    UPD0_OPC = 6'b100100,
  parameter logic [OPC_W-1:0]    UPD1_OPC = 6'b100010
) (
  input  logic [INSN_W-1:0] insn,
  output sched_op_e         op,
  output logic [IDX_W-1:0]  idx_d,
  output logic [IDX_W-1:0]  idx_n,
  output logic [IDX_W-1:0]  idx_m
);

  logic              prefix_hit;
  logic [OPC_W-1:0]  opc;

  assign prefix_hit = (insn[31:21] == PREFIX);
  assign opc        = insn[15:10];
  assign idx_m      = insn[20:16];
  assign idx_n      = insn[9:5];
  assign idx_d      = insn[4:0];

  always_comb begin
    op = SCHED_ILLEGAL;
    if (prefix_hit) begin
      if (opc == UPD1_OPC) begin
        op = SCHED_UPD1;
      end else if (opc == UPD0_OPC) begin
        op = SCHED_UPD0;
      end
    end
  end

endmodule

// File: rtl/sha_sched_sigma.sv
module sha_sched_sigma #(
  parameter int unsigned W     = 64,
  parameter int unsigned ROT_A = 1,
  parameter int unsigned ROT_B = 8,
  parameter int unsigned SHR   = 7
) (
  input  logic [W-1:0] v,
  output logic [W-1:0] y
);

  localparam int unsigned BACK_A = W - ROT_A;
  localparam int unsigned BACK_B = W - ROT_B;

  logic [W-1:0] rot_a;
  logic [W-1:0] rot_b;
  logic [W-1:0] shr_v;

  assign rot_a = (v >> ROT_A) | (v << BACK_A);
  assign rot_b = (v >> ROT_B) | (v << BACK_B);
  assign shr_v = v >> SHR;
  assign y     = rot_a ^ rot_b ^ shr_v;

endmodule

// File: rtl/sha_sched_lane_add.sv
module sha_sched_lane_add #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] sum
);

  logic [W-1:0] ab;

  assign ab  = a + b;
  assign sum = ab + c;

endmodule

// File: rtl/sha_sched_unit.sv
module sha_sched_unit
  import sha_sched_pkg::*;
#(
  parameter int unsigned      LANE_W   = 64,
  parameter logic [OPC_W-1:0] UPD0_OPC = 6'b100100,
  parameter logic [OPC_W-1:0] UPD1_OPC = 6'b100010
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [INSN_W-1:0]    in_insn,
  input  logic [2*LANE_W-1:0]  in_opd,
  input  logic [2*LANE_W-1:0]  in_opn,
  input  logic [2*LANE_W-1:0]  in_opm,
  output logic [IDX_W-1:0]     src_n_idx,
  output logic [IDX_W-1:0]     src_m_idx,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2*LANE_W-1:0]  out_result,
  output logic [IDX_W-1:0]     out_dst_idx,
  output logic                 out_wr_en,
  output logic                 out_illegal
);

  localparam int unsigned LANES = 2;
  localparam int unsigned VEC_W = LANES * LANE_W;

  // ---------------- decode ----------------
  sched_op_e            dec_op;
  logic [IDX_W-1:0]     dec_d;

  sha_sched_decode #(
    .UPD0_OPC (UPD0_OPC),
    .UPD1_OPC (UPD1_OPC)
  ) u_decode (
    .insn  (in_insn),
    .op    (dec_op),
    .idx_d (dec_d),
    .idx_n (src_n_idx),
    .idx_m (src_m_idx)
  );

  // ---------------- handshake ----------------
  logic s1_valid_q, s1_valid_d;
  logic s2_valid_q, s2_valid_d;
  logic s2_adv;
  logic s1_load;
  logic s2_load;

  assign s2_adv   = !s2_valid_q || out_ready;
  assign in_ready = !s1_valid_q || s2_adv;
  assign s1_load  = in_valid && in_ready;
  assign s2_load  = s2_adv && s1_valid_q;

  // ---------------- stage 1: sigma and operand arrangement ----------------
  logic [LANE_W-1:0] st1_x [LANES];
  logic [LANE_W-1:0] st1_y [LANES];
  logic [LANE_W-1:0] st1_s [LANES];

  logic [LANE_W-1:0] s1_x_q [LANES];
  logic [LANE_W-1:0] s1_y_q [LANES];
  logic [LANE_W-1:0] s1_s_q [LANES];
  logic [LANE_W-1:0] s1_x_d [LANES];
  logic [LANE_W-1:0] s1_y_d [LANES];
  logic [LANE_W-1:0] s1_s_d [LANES];
  sched_op_e         s1_op_q, s1_op_d;
  logic [IDX_W-1:0]  s1_dst_q, s1_dst_d;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_st1
    logic [LANE_W-1:0] d_word;
    logic [LANE_W-1:0] m_word;
    logic [LANE_W-1:0] n_word;
    logic [LANE_W-1:0] sig0_in;
    logic [LANE_W-1:0] sig0_out;
    logic [LANE_W-1:0] sig1_out;

    assign d_word = in_opd[ln*LANE_W +: LANE_W];
    assign m_word = in_opm[ln*LANE_W +: LANE_W];
    assign n_word = in_opn[ln*LANE_W +: LANE_W];

    // word 0 mixes the upper destination word, word 1 the lower first-source word
    if (ln == 0) begin : g_sel_lo
      assign sig0_in = in_opd[LANE_W +: LANE_W];
    end else begin : g_sel_hi
      assign sig0_in = in_opn[0 +: LANE_W];
    end

    sha_sched_sigma #(
      .W (LANE_W), .ROT_A (1), .ROT_B (8), .SHR (7)
    ) u_sig0 (
      .v (sig0_in),
      .y (sig0_out)
    );

    sha_sched_sigma #(
      .W (LANE_W), .ROT_A (19), .ROT_B (61), .SHR (6)
    ) u_sig1 (
      .v (n_word),
      .y (sig1_out)
    );

    always_comb begin
      st1_x[ln] = '0;
      st1_y[ln] = '0;
      st1_s[ln] = '0;
      unique case (dec_op)
        SCHED_UPD0: begin
          st1_x[ln] = d_word;
          st1_s[ln] = sig0_out;
        end
        SCHED_UPD1: begin
          st1_x[ln] = d_word;
          st1_y[ln] = m_word;
          st1_s[ln] = sig1_out;
        end
        default: ;
      endcase
    end
  end

  // stage 1 next state
  always_comb begin
    s1_valid_d = s1_valid_q;
    s1_op_d    = s1_op_q;
    s1_dst_d   = s1_dst_q;
    for (int ln = 0; ln < LANES; ln++) begin
      s1_x_d[ln] = s1_x_q[ln];
      s1_y_d[ln] = s1_y_q[ln];
      s1_s_d[ln] = s1_s_q[ln];
    end
    if (in_ready) begin
      s1_valid_d = in_valid;
    end
    if (s1_load) begin
      s1_op_d  = dec_op;
      s1_dst_d = dec_d;
      for (int ln = 0; ln < LANES; ln++) begin
        s1_x_d[ln] = st1_x[ln];
        s1_y_d[ln] = st1_y[ln];
        s1_s_d[ln] = st1_s[ln];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    s1_op_q  <= s1_op_d;
    s1_dst_q <= s1_dst_d;
    for (int ln = 0; ln < LANES; ln++) begin
      s1_x_q[ln] <= s1_x_d[ln];
      s1_y_q[ln] <= s1_y_d[ln];
      s1_s_q[ln] <= s1_s_d[ln];
    end
  end

  // ---------------- stage 2: lane additions ----------------
  logic [VEC_W-1:0]  st2_sum;
  logic [VEC_W-1:0]  s2_res_q, s2_res_d;
  sched_op_e         s2_op_q, s2_op_d;
  logic [IDX_W-1:0]  s2_dst_q, s2_dst_d;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_st2
    sha_sched_lane_add #(
      .W (LANE_W)
    ) u_add (
      .a   (s1_x_q[ln]),
      .b   (s1_y_q[ln]),
      .c   (s1_s_q[ln]),
      .sum (st2_sum[ln*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    s2_valid_d = s2_valid_q;
    s2_res_d   = s2_res_q;
    s2_op_d    = s2_op_q;
    s2_dst_d   = s2_dst_q;
    if (s2_adv) begin
      s2_valid_d = s1_valid_q;
    end
    if (s2_load) begin
      s2_res_d = st2_sum;
      s2_op_d  = s1_op_q;
      s2_dst_d = s1_dst_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid_q <= 1'b0;
    end else begin
      s2_valid_q <= s2_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    s2_res_q <= s2_res_d;
    s2_op_q  <= s2_op_d;
    s2_dst_q <= s2_dst_d;
  end

  // ---------------- outputs ----------------
  assign out_valid   = s2_valid_q;
  assign out_result  = s2_res_q;
  assign out_dst_idx = s2_dst_q;
  assign out_illegal = s2_valid_q && (s2_op_q == SCHED_ILLEGAL);
  assign out_wr_en   = s2_valid_q && (s2_op_q != SCHED_ILLEGAL);

endmodule

// File: rtl/sha_sched_unit_chk.sv
module sha_sched_unit_chk #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_result,
  input logic [IDX_W-1:0] out_dst_idx,
  input logic             out_wr_en,
  input logic             out_illegal
);

  assert_illegal_nowrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> !out_wr_en);

  assert_one_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({out_wr_en, out_illegal}));

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_dst_idx) && $stable(out_wr_en) && $stable(out_illegal)));

  assert_backpressure_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R12: assert (!out_valid && in_ready);
    end
  end

endmodule

bind sha_sched_unit sha_sched_unit_chk #(
  .VEC_W (2*LANE_W),
  .IDX_W (5)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_dst_idx (out_dst_idx),
  .out_wr_en   (out_wr_en),
  .out_illegal (out_illegal)
);

// File: tb/sha_sched_unit_bench.sv
module sha_sched_unit_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_insn = '0;
  logic [127:0] in_opd = '0;
  logic [127:0] in_opn = '0;
  logic [127:0] in_opm = '0;
  logic [4:0]   src_n_idx;
  logic [4:0]   src_m_idx;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_result;
  logic [4:0]   out_dst_idx;
  logic         out_wr_en;
  logic         out_illegal;

  always #5 clk = ~clk;

  sha_sched_unit u_sha_sched_unit (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready), .in_insn (in_insn),
    .in_opd (in_opd), .in_opn (in_opn), .in_opm (in_opm),
    .src_n_idx (src_n_idx), .src_m_idx (src_m_idx),
    .out_valid (out_valid), .out_ready (out_ready), .out_result (out_result),
    .out_dst_idx (out_dst_idx), .out_wr_en (out_wr_en), .out_illegal (out_illegal)
  );

  typedef struct {
    logic [127:0] res;
    logic [4:0]   dst;
    logic         ill;
    string        tag;
    int           acc;
    int           rdy;
  } exp_t;

  exp_t         q[$];
  int           checks = 0;
  int           errors = 0;
  int           edge_n = 0;
  int           last_h = 0;
  bit           done = 0;
  bit           prev_stall = 0;
  logic [127:0] prev_res = '0;

  always @(posedge clk) edge_n <= edge_n + 1;

  // ---------------- behavioural reference ----------------
  function automatic logic [63:0] rotr(input logic [63:0] v, input int r);
    return (v >> r) | (v << (64 - r));
  endfunction

  function automatic logic [63:0] sg0(input logic [63:0] v);
    return rotr(v, 1) ^ rotr(v, 8) ^ (v >> 7);
  endfunction

  function automatic logic [63:0] sg1(input logic [63:0] v);
    return rotr(v, 19) ^ rotr(v, 61) ^ (v >> 6);
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] m,
                                     input logic [4:0] n, input logic [4:0] d);
    return {11'b11001110011, m, opc, n, d};
  endfunction

  function automatic exp_t model(input logic [31:0] w, input logic [127:0] d,
                                 input logic [127:0] n, input logic [127:0] m);
    exp_t e;
    e.dst = w[4:0];
    e.ill = 1'b0;
    e.res = '0;
    e.tag = "";
    e.acc = 0;
    e.rdy = 0;
    if (w[31:21] == 11'b11001110011 && w[15:10] == 6'b100010) begin
      e.res[63:0]   = d[63:0] + m[63:0] + sg1(n[63:0]);
      e.res[127:64] = d[127:64] + m[127:64] + sg1(n[127:64]);
    end else if (w[31:21] == 11'b11001110011 && w[15:10] == 6'b100100) begin
      e.res[63:0]   = d[63:0] + sg0(d[127:64]);
      e.res[127:64] = d[127:64] + sg0(n[63:0]);
    end else begin
      e.ill = 1'b1;
    end
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, then update the model for the coming edge
  task automatic step(input bit iv, input logic [31:0] w, input logic [127:0] d,
                      input logic [127:0] n, input logic [127:0] m,
                      input bit ordy, input string tag);
    bit   exp_v;
    bit   exp_ir;
    exp_t e;
    @(negedge clk);
    in_valid  = iv;
    in_insn   = w;
    in_opd    = d;
    in_opn    = n;
    in_opm    = m;
    out_ready = ordy;
    #1;
    exp_v  = (q.size() > 0) && (edge_n >= q[0].rdy);
    exp_ir = !((q.size() == 2) && !ordy);
    chk(out_valid == exp_v, "R9", "out_valid", 128'(out_valid), 128'(exp_v));
    chk(in_ready == exp_ir, "R11", "in_ready", 128'(in_ready), 128'(exp_ir));
    if (prev_stall)
      chk(out_result == prev_res, "R10", "held result", out_result, prev_res);
    if (iv) begin
      chk(src_n_idx == w[9:5], "R1", "src_n_idx", 128'(src_n_idx), 128'(w[9:5]));
      chk(src_m_idx == w[20:16], "R1", "src_m_idx", 128'(src_m_idx), 128'(w[20:16]));
    end
    if (out_valid && exp_v) begin
      chk(out_result == q[0].res, q[0].tag, "result", out_result, q[0].res);
      chk(out_dst_idx == q[0].dst, "R8", "dst", 128'(out_dst_idx), 128'(q[0].dst));
      chk(out_illegal == q[0].ill, "R2", "illegal", 128'(out_illegal), 128'(q[0].ill));
      chk(out_wr_en == !q[0].ill, "R2", "wr_en", 128'(out_wr_en), 128'(!q[0].ill));
    end
    if (out_valid && out_ready && q.size() > 0) begin
      void'(q.pop_front());
      last_h = edge_n + 1;
      if (q.size() > 0)
        q[0].rdy = (q[0].acc + 1 > last_h) ? q[0].acc + 1 : last_h;
    end
    if (in_valid && in_ready) begin
      e     = model(w, d, n, m);
      e.tag = tag;
      e.acc = edge_n + 1;
      e.rdy = (q.size() == 0) ? ((e.acc + 1 > last_h) ? e.acc + 1 : last_h) : 0;
      q.push_back(e);
    end
    prev_stall = out_valid && !out_ready;
    prev_res   = out_result;
  endtask

  function automatic logic [127:0] rv();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] dd;
    logic [127:0] nn;
    // reset phase, R12
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk(!out_valid, "R12", "out_valid in reset", 128'(out_valid), 128'(0));
      chk(in_ready, "R12", "in_ready in reset", 128'(in_ready), 128'(1));
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R4: sigma1 isolated, d = m = 0
    step(1, mk(6'b100010, 5'd0, 5'd1, 5'd2), '0, {64'h8000_0000_0000_0000, 64'h1}, '0, 1, "R4");
    // R3: sigma0 isolated, lower destination word zero
    step(1, mk(6'b100100, 5'd3, 5'd4, 5'd5), {64'h0123_4567_89ab_cdef, 64'h0},
         {64'h0, 64'h8000_0000_0000_0001}, '0, 1, "R3");
    // R5: m ignored, same d and n with two different m
    dd = rv(); nn = rv();
    step(1, mk(6'b100100, 5'd6, 5'd7, 5'd8), dd, nn, '0, 1, "R5");
    step(1, mk(6'b100100, 5'd9, 5'd7, 5'd8), dd, nn, '1, 1, "R5");
    // R7 / R6: wrap in low word, no carry into high word
    step(1, mk(6'b100010, 5'd10, 5'd11, 5'd12), {64'h0, 64'hffff_ffff_ffff_ffff},
         '0, {64'h0, 64'h0000_0000_0000_0002}, 1, "R7");
    step(1, mk(6'b100010, 5'd13, 5'd14, 5'd15), {64'h1, 64'hffff_ffff_ffff_ffff},
         {64'h0, 64'h40}, {64'h0, 64'hffff_ffff_ffff_ffff}, 1, "R6");
    // R1 / R8: extreme field values
    step(1, mk(6'b100010, 5'd17, 5'd5, 5'd31), rv(), rv(), rv(), 1, "R1");
    // R2: neighbouring opcodes and a bad prefix
    step(1, mk(6'b100000, 5'd1, 5'd2, 5'd3), rv(), rv(), rv(), 1, "R2");
    step(1, mk(6'b100001, 5'd1, 5'd2, 5'd4), rv(), rv(), rv(), 1, "R2");
    step(1, mk(6'b100011, 5'd1, 5'd2, 5'd5), rv(), rv(), rv(), 1, "R2");
    step(1, mk(6'b100010, 5'd1, 5'd2, 5'd6) ^ 32'h8000_0000, rv(), rv(), rv(), 1, "R2");
    // R9: back-to-back stream
    for (int i = 0; i < 16; i++)
      step(1, mk((i % 2) ? 6'b100010 : 6'b100100, 5'(i), 5'(i + 3), 5'(i + 7)),
           rv(), rv(), rv(), 1, "R9");
    // random traffic with stalls, R10 and R11
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w;
      int          sel;
      string       t;
      sel = int'($urandom % 6);
      case (sel)
        0, 1: begin w = mk(6'b100010, 5'($urandom), 5'($urandom), 5'($urandom)); t = "R6"; end
        2, 3: begin w = mk(6'b100100, 5'($urandom), 5'($urandom), 5'($urandom)); t = "R5"; end
        4:    begin w = mk(6'b100000 | 6'($urandom % 4), 5'($urandom), 5'($urandom), 5'($urandom));
                    t = (w[15:10] == 6'b100010) ? "R6" : "R2"; end
        default: begin w = $urandom; t = "R2"; end
      endcase
      step(($urandom % 4) != 0, w, rv(), rv(), rv(), ($urandom % 3) != 0, t);
    end
    for (int i = 0; i < 8; i++)
      step(0, '0, '0, '0, '0, 1, "R9");
    chk(q.size() == 0, "R9", "drained", 128'(q.size()), 128'(0));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule